// File: doc/BRIEF.md
# Condition field masked match unit

This unit tests a 4-bit condition field against a 4-bit pattern, bit by bit, under a 4-bit mask. Each result bit is 1 only where the mask bit is set and the pattern bit equals the tested bit. The unit works in two directions, chosen per operation.

In the move-from direction, the tested bits come from one of eight condition fields held in the unit. The 4-bit outcome goes to the low nibble of a 64-bit destination value, with all upper bits zero. An optional summary of that value (less-than, greater-than and equal against zero, plus a sticky-overflow copy) can be written into field 0.

In the move-to direction, the tested bits are the four low bits of a 64-bit source value, taken in reversed order. The outcome is written into the selected condition field. A merge option keeps the old field bits wherever the mask is clear.

All indices below use LSB-0 numbering. Field k occupies `cr_o[31-4k : 28-4k]`, so field 0 is the top nibble. Inside a field, mask, pattern and result, position p means bit p of the nibble. Operations are accepted on `op_valid_i` and take effect at the next rising clock edge. The reset input is asynchronous and active low, and its release is synchronised inside the unit. The unit leaves reset two clock edges after `rst_n` rises.

Top module: `cr_match_unit`

## Requirements
- R1: After reset, `cr_o` is 0, `gpr_we_o` is 0 and `gpr_wdata_o` is 0.
- R2: A valid move-from operation (`op_dir_i`=0) sets `gpr_we_o` to 1 for exactly the next cycle. It sets `gpr_wdata_o[p]` = `mask_i[p]` AND (`mode_i[p]` == bit p of field `fld_sel_i`), for p = 0..3.
- R3: Bits 63:4 of `gpr_wdata_o` are always 0. `gpr_wdata_o` holds its value in cycles without a move-from operation.
- R4: A move-from operation with `rc_i`=1 writes field 0 with {LT, GT, EQ, SO}, LT in bit 31 and SO in bit 28. LT, GT and EQ are a signed comparison of the new 64-bit destination value with zero, and SO is `so_i`. Exactly one of LT, GT and EQ is set.
- R5: A valid move-to operation (`op_dir_i`=1) with `merge_i`=0 writes field `fld_sel_i` with bit p = `mask_i[p]` AND (`mode_i[p]` == `gpr_src_i[3-p]`). The source bits are taken in reversed order.
- R6: With `merge_i`=1, the move-to result is ORed with (old field AND NOT `mask_i`). With `mask_i`=0 and merging, the field is therefore unchanged.
- R7: A field write changes only the selected field. The other seven fields keep their values.
- R8: With `op_valid_i`=0, `cr_o` and `gpr_wdata_o` keep their values, and `gpr_we_o` is 0 in the next cycle.
- R9: A move-to operation never raises `gpr_we_o`, and `rc_i` has no effect on it. A move-from operation with `rc_i`=0 leaves `cr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_dir_i | input | 1 | 0 = move-from (field to register), 1 = move-to (register to field) |
| fld_sel_i | input | 3 | Condition field index |
| mask_i | input | 4 | Per-bit enable of the match |
| mode_i | input | 4 | Pattern to compare against |
| merge_i | input | 1 | Move-to: keep old field bits where mask is clear |
| rc_i | input | 1 | Move-from: also write the summary into field 0 |
| so_i | input | 1 | Sticky overflow copied into the summary |
| gpr_src_i | input | 64 | Source register value (move-to uses bits 3:0) |
| gpr_wdata_o | output | 64 | Destination register value |
| gpr_we_o | output | 1 | Destination write strobe, one cycle per move-from |
| cr_o | output | 32 | Current contents of the eight condition fields |

## Verification
Condition state lives only in the 32-bit field register, and that register is visible on `cr_o`. A wrong bit there therefore shows on the port in the cycle after the faulty write. It shows again in the next move-from of that field, where a wrong nibble reaches `gpr_wdata_o` one edge after the request. A fault in the bit reversal or in the merge path tends to hit only some mask and pattern combinations. For that reason every field value is crossed with every mask and pattern, in both directions, with and without merging.

// File: rtl/cr_match_pkg.sv
package cr_match_pkg;

  typedef enum logic {
    DIR_FROM = 1'b0,
    DIR_TO   = 1'b1
  } dir_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } summ_t;

endpackage

// File: rtl/cr_match_cmp.sv
module cr_match_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] res_o
);

  for (genvar p = 0; p < W; p++) begin : g_bit
    assign res_o[p] = mask_i[p] & ~(mode_i[p] ^ data_i[p]);
  end

endmodule

// File: rtl/cr_match_summary.sv
module cr_match_summary
  import cr_match_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] value_i,
  input  logic         so_i,
  output summ_t        summ_o
);

  logic is_neg;
  logic is_zero;

  always_comb begin
    is_neg      = value_i[W-1];
    is_zero     = (value_i == '0);
    summ_o.lt   = is_neg;
    summ_o.eq   = is_zero;
    summ_o.gt   = ~is_neg & ~is_zero;
    summ_o.so   = so_i;
  end

  // R4: exactly one relation flag
  always_comb begin
    if (!$isunknown(value_i)) begin
      a_r4_one_relation: assert ($countones({summ_o.lt, summ_o.gt, summ_o.eq}) == 1)
        else $error("summary relation flags not exclusive");
    end
  end

endmodule

// File: rtl/cr_match_crfile.sv
module cr_match_crfile #(
  parameter int NUM_FLD = 8,
  parameter int FLD_W   = 4,
  localparam int SEL_W  = $clog2(NUM_FLD),
  localparam int CR_W   = NUM_FLD * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [FLD_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [FLD_W-1:0] rd_data_o,
  output logic [CR_W-1:0]  cr_o
);

  logic [CR_W-1:0] cr_q;
  logic [CR_W-1:0] cr_d;

  always_comb begin
    cr_d = cr_q;
    if (wr_en_i) begin
      cr_d[(NUM_FLD - 1 - int'(wr_sel_i)) * FLD_W +: FLD_W] = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
    end else if (wr_en_i) begin
      cr_q <= cr_d;
    end
  end

  assign rd_data_o = cr_q[(NUM_FLD - 1 - int'(rd_sel_i)) * FLD_W +: FLD_W];
  assign cr_o      = cr_q;

  function automatic logic [CR_W-1:0] fld_mask(input logic [SEL_W-1:0] s);
    logic [CR_W-1:0] ones;
    ones = '0;
    ones[FLD_W-1:0] = '1;
    return ones << ((NUM_FLD - 1 - int'(s)) * FLD_W);
  endfunction

  // R8: no write, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cr_q))
    else $error("field register changed without a write");

  // R7: a write leaves the other fields alone
  a_r7_other_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (((cr_q ^ $past(cr_q)) & ~fld_mask($past(wr_sel_i))) == '0))
    else $error("write disturbed a non-selected field");

  // R7: the selected field takes the written nibble
  a_r7_target_field: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((cr_q & fld_mask($past(wr_sel_i))) ==
                 ({{(CR_W-FLD_W){1'b0}}, $past(wr_data_i)}
                  << ((NUM_FLD - 1 - int'($past(wr_sel_i))) * FLD_W))))
    else $error("selected field not written");

endmodule

// File: rtl/cr_match_unit.sv
module cr_match_unit
  import cr_match_pkg::*;
#(
  parameter int GPR_W   = 64,
  parameter int NUM_FLD = 8,
  parameter int FLD_W   = 4,
  localparam int SEL_W  = $clog2(NUM_FLD),
  localparam int CR_W   = NUM_FLD * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic             op_dir_i,
  input  logic [SEL_W-1:0] fld_sel_i,
  input  logic [FLD_W-1:0] mask_i,
  input  logic [FLD_W-1:0] mode_i,
  input  logic             merge_i,
  input  logic             rc_i,
  input  logic             so_i,
  input  logic [GPR_W-1:0] gpr_src_i,
  output logic [GPR_W-1:0] gpr_wdata_o,
  output logic             gpr_we_o,
  output logic [CR_W-1:0]  cr_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_loc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_loc_n = rst_sync_q[1];

  dir_e dir;
  assign dir = dir_e'(op_dir_i);

  logic op_from;
  logic op_to;
  assign op_from = op_valid_i & (dir == DIR_FROM);
  assign op_to   = op_valid_i & (dir == DIR_TO);

  // field storage
  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [FLD_W-1:0] wr_data;
  logic [FLD_W-1:0] fld_old;

  cr_match_crfile #(
    .NUM_FLD (NUM_FLD),
    .FLD_W   (FLD_W)
  ) u_crfile (
    .clk       (clk),
    .rst_n     (rst_loc_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .rd_sel_i  (fld_sel_i),
    .rd_data_o (fld_old),
    .cr_o      (cr_o)
  );

  // move-from match
  logic [FLD_W-1:0] from_res;

  cr_match_cmp #(.W(FLD_W)) u_cmp_from (
    .mask_i (mask_i),
    .mode_i (mode_i),
    .data_i (fld_old),
    .res_o  (from_res)
  );

  // move-to match, source bits reversed
  logic [FLD_W-1:0] src_rev;
  logic             unused_src_hi;

  for (genvar p = 0; p < FLD_W; p++) begin : g_rev
    assign src_rev[p] = gpr_src_i[FLD_W-1-p];
  end
  assign unused_src_hi = ^gpr_src_i[GPR_W-1:FLD_W];

  logic [FLD_W-1:0] to_res;
  logic [FLD_W-1:0] to_merged;

  cr_match_cmp #(.W(FLD_W)) u_cmp_to (
    .mask_i (mask_i),
    .mode_i (mode_i),
    .data_i (src_rev),
    .res_o  (to_res)
  );

  always_comb begin
    to_merged = to_res;
    if (merge_i) begin
      to_merged = to_res | (fld_old & ~mask_i);
    end
  end

  // destination value and its summary
  logic [GPR_W-1:0] from_word;
  summ_t            summ;

  assign from_word = {{(GPR_W-FLD_W){1'b0}}, from_res};

  cr_match_summary #(.W(GPR_W)) u_summary (
    .value_i (from_word),
    .so_i    (so_i),
    .summ_o  (summ)
  );

  // field write port selection
  always_comb begin
    wr_en   = op_to | (op_from & rc_i);
    wr_sel  = op_to ? fld_sel_i : '0;
    wr_data = op_to ? to_merged : FLD_W'(summ);
  end

  // destination output registers
  logic [GPR_W-1:0] wdata_d;
  logic [GPR_W-1:0] wdata_q;
  logic             wdata_en;
  logic             we_d;
  logic             we_q;

  always_comb begin
    wdata_en = op_from;
    wdata_d  = from_word;
    we_d     = op_from;
  end

  always_ff @(posedge clk or negedge rst_loc_n) begin
    if (!rst_loc_n) begin
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= we_d;
      if (wdata_en) begin
        wdata_q <= wdata_d;
      end
    end
  end

  assign gpr_wdata_o = wdata_q;
  assign gpr_we_o    = we_q;

  // R3: upper destination bits stay zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_loc_n)
    gpr_wdata_o[GPR_W-1:FLD_W] == '0)
    else $error("upper destination bits set");

  // R2: strobe only after a move-from request
  a_r2_we_source: assert property (@(posedge clk) disable iff (!rst_loc_n)
    gpr_we_o |-> $past(op_valid_i && !op_dir_i))
    else $error("write strobe without move-from");

  // R2: all-zero mask gives an all-zero result
  a_r2_zero_mask: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (op_from && mask_i == '0) |=> (gpr_wdata_o == '0))
    else $error("zero mask produced a set bit");

  // R9: move-to never strobes the destination
  a_r9_to_no_we: assert property (@(posedge clk) disable iff (!rst_loc_n)
    op_to |=> !gpr_we_o)
    else $error("move-to raised the write strobe");

  // R6: merging under an empty mask keeps the fields
  a_r6_merge_empty: assert property (@(posedge clk) disable iff (!rst_loc_n)
    (op_to && merge_i && mask_i == '0) |=> $stable(cr_o))
    else $error("empty-mask merge changed a field");

  // R8: idle cycles keep the destination value
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_loc_n)
    !op_valid_i |=> ($stable(gpr_wdata_o) && !gpr_we_o))
    else $error("idle cycle changed the destination");

endmodule

// File: tb/cr_match_unit_tb.sv
`timescale 1ns/1ps
module cr_match_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        op_valid_i;
  logic        op_dir_i;
  logic [2:0]  fld_sel_i;
  logic [3:0]  mask_i;
  logic [3:0]  mode_i;
  logic        merge_i;
  logic        rc_i;
  logic        so_i;
  logic [63:0] gpr_src_i;
  logic [63:0] gpr_wdata_o;
  logic        gpr_we_o;
  logic [31:0] cr_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_cr;
  logic [63:0] m_wd;

  cr_match_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .op_dir_i    (op_dir_i),
    .fld_sel_i   (fld_sel_i),
    .mask_i      (mask_i),
    .mode_i      (mode_i),
    .merge_i     (merge_i),
    .rc_i        (rc_i),
    .so_i        (so_i),
    .gpr_src_i   (gpr_src_i),
    .gpr_wdata_o (gpr_wdata_o),
    .gpr_we_o    (gpr_we_o),
    .cr_o        (cr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fld_of(input logic [31:0] cr, input int sel);
    return 4'((cr >> (28 - 4 * sel)) & 32'hF);
  endfunction

  function automatic logic [31:0] fld_set(input logic [31:0] cr, input int sel,
                                          input logic [3:0] v);
    logic [31:0] clr;
    clr = ~(32'hF << (28 - 4 * sel));
    return (cr & clr) | ({28'd0, v} << (28 - 4 * sel));
  endfunction

  function automatic logic [3:0] exp_from(input logic [3:0] fld, input logic [3:0] mk,
                                          input logic [3:0] md);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = mk[p] && (md[p] == fld[p]);
    return r;
  endfunction

  function automatic logic [3:0] exp_to(input logic [63:0] g, input logic [3:0] mk,
                                        input logic [3:0] md, input bit mg,
                                        input logic [3:0] old);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = mk[p] && (md[p] == g[3 - p]);
    if (mg) r = r | (old & ~mk);
    return r;
  endfunction

  task automatic do_op(input bit v, input bit dir, input int sel, input logic [3:0] mk,
                       input logic [3:0] md, input bit mg, input bit rc, input bit so,
                       input logic [63:0] g);
    logic [3:0] old;
    logic [3:0] res;
    bit         exp_we;
    string      crtag;
    old    = fld_of(m_cr, sel);
    exp_we = v && !dir;
    crtag  = "R8";
    if (v && !dir) begin
      res  = exp_from(old, mk, md);
      m_wd = {60'd0, res};
      if (rc) begin
        m_cr  = fld_set(m_cr, 0, {1'b0, res != 4'd0, res == 4'd0, so});
        crtag = "R4";
      end else begin
        crtag = "R9";
      end
    end else if (v && dir) begin
      m_cr  = fld_set(m_cr, sel, exp_to(g, mk, md, mg, old));
      crtag = mg ? "R6_R7" : "R5_R7";
    end
    @(negedge clk);
    op_valid_i = v;
    op_dir_i   = dir;
    fld_sel_i  = 3'(sel);
    mask_i     = mk;
    mode_i     = md;
    merge_i    = mg;
    rc_i       = rc;
    so_i       = so;
    gpr_src_i  = g;
    @(negedge clk);
    check(gpr_we_o == exp_we, exp_we ? "R2" : (v ? "R9" : "R8"),
          64'(gpr_we_o), 64'(exp_we));
    check(gpr_wdata_o == m_wd, (v && !dir) ? "R2_R3" : "R3", gpr_wdata_o, m_wd);
    check(cr_o == m_cr, crtag, 64'(cr_o), 64'(m_cr));
    op_valid_i = 1'b0;
  endtask

  // loads a field with value fv through a plain move-to
  task automatic load_fld(input int sel, input logic [3:0] fv);
    logic [63:0] g;
    g = {$urandom(), $urandom()};
    for (int p = 0; p < 4; p++) g[3 - p] = ~fv[p];
    do_op(1'b1, 1'b1, sel, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0, g);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst_n = 1'b0; op_valid_i = 1'b0; op_dir_i = 1'b0; fld_sel_i = '0;
    mask_i = '0; mode_i = '0; merge_i = 1'b0; rc_i = 1'b0; so_i = 1'b0;
    gpr_src_i = '0;
    m_cr = '0; m_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(cr_o == 32'd0, "R1", 64'(cr_o), 64'd0);
    check(gpr_we_o == 1'b0, "R1", 64'(gpr_we_o), 64'd0);
    check(gpr_wdata_o == 64'd0, "R1", gpr_wdata_o, 64'd0);

    // directed corner cases
    // R5: reversed source order, field 7 is the bottom nibble
    do_op(1, 1, 7, 4'hF, 4'h0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF1);
    check(cr_o[3:0] == 4'b0111, "R5", 64'(cr_o[3:0]), 64'h7);
    // R7: field 0 is the top nibble
    do_op(1, 1, 0, 4'hF, 4'hF, 0, 0, 0, 64'h0000_0000_0000_000C);
    check(cr_o[31:28] == 4'b0011, "R7", 64'(cr_o[31:28]), 64'h3);
    // R6: merge under empty mask keeps the field
    do_op(1, 1, 7, 4'h0, 4'hA, 1, 0, 0, 64'h5);
    // R2/R4: zero result with rc sets EQ and SO
    do_op(1, 0, 7, 4'h0, 4'h0, 0, 1, 1, 64'h0);
    check(cr_o[31:28] == 4'b0011, "R4", 64'(cr_o[31:28]), 64'h3);
    // R4: nonzero result sets GT
    do_op(1, 0, 7, 4'hF, 4'h7, 0, 1, 0, 64'h0);
    check(cr_o[31:28] == 4'b0100, "R4", 64'(cr_o[31:28]), 64'h4);
    // R9: rc on move-to has no effect on the strobe
    do_op(1, 1, 3, 4'h5, 4'h5, 0, 1, 1, 64'h9);
    // R8: idle cycles
    do_op(0, 0, 2, 4'hF, 4'hF, 1, 1, 1, 64'hF);

    // exhaustive: field value x mask x pattern, both directions
    for (int fv = 0; fv < 16; fv++) begin
      for (int mk = 0; mk < 16; mk++) begin
        for (int md = 0; md < 16; md++) begin
          int sel;
          sel = int'($urandom_range(0, 7));
          load_fld(sel, 4'(fv));
          do_op(1, 0, sel, 4'(mk), 4'(md), 0, bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)), {$urandom(), $urandom()});
          sel = int'($urandom_range(0, 7));
          load_fld(sel, 4'(fv));
          do_op(1, 1, sel, 4'(mk), 4'(md), bit'($urandom_range(0, 1)), 0, 0,
                {$urandom(), $urandom()});
        end
      end
    end

    // random mix including idle cycles
    for (int i = 0; i < 3000; i++) begin
      do_op(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 7)), 4'($urandom()), 4'($urandom()),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), {$urandom(), $urandom()});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule